// File: doc/BRIEF.md
# Byte-Addressed Program Counter with Staged Upper Bytes

This block holds the 21-bit fetch address of a small microcontroller core. The address counts bytes, and instructions are two bytes wide, so the counter steps by two and its least significant bit is always zero. The address is stored as three fields: a low byte (bits 7:0), a middle byte (bits 15:8) and a 5-bit upper field (bits 20:16).

Software can reach only the low byte directly. The middle and upper fields are reached through two staging latches, which software can read and write freely. Writing the low byte commits both latches into the counter in the same cycle, so a computed jump lands on a whole new address at once. Reading the low byte does the reverse: it copies the current middle and upper fields into the latches, so software can then read them. Jumps, calls, branches and returns use a separate direct-load port that replaces the full address and leaves the latches untouched.

Top module: `pc_latch_unit`

## Requirements
- R1: After a synchronous active-low reset, the fetch address is 0 and both staging latches read 0.
- R2: When only the advance strobe is asserted, the fetch address increases by 2 at the next clock edge, wrapping modulo 2^21 (0x1FFFFE advances to 0).
- R3: Bit 0 of the fetch address is 0 in every cycle, including after a direct load or a low-byte write whose bit 0 is 1.
- R4: A register write with select 0 (low byte) sets the fetch address to {upper latch, middle latch, write data with bit 0 cleared} at the next edge.
- R5: With select 0, read data shows the current fetch address bits 7:0. A read strobe with select 0 and no write copies fetch address bits 15:8 into the middle latch and bits 20:16 into the upper latch at the next edge.
- R6: A direct load replaces the whole fetch address with the load value (bit 0 cleared) and leaves both latches unchanged.
- R7: If a direct load and a low-byte write occur in the same cycle, the direct load sets the address. If a low-byte write and an advance coincide, the write sets the address and the advance is dropped.
- R8: Select 1 is the middle latch (8 bits) and select 2 is the upper latch. Writes to the upper latch store only data bits 4:0, and read data bits 7:5 are 0 with select 2.
- R9: Writes with select 1, 2 or 3 leave the fetch address unchanged. Select 3 maps to nothing: its reads return 0 and its writes change no state.
- R10: In a cycle with no advance, no direct load and no low-byte write, the fetch address holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv | input | 1 | Advance to the next instruction (+2) |
| ld_vld | input | 1 | Direct load strobe for a jump, call, branch or return |
| ld_addr | input | 21 | Direct load target address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (only its side effect uses it) |
| reg_sel | input | 2 | Register select: 0 low byte, 1 middle latch, 2 upper latch, 3 none |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the current select |
| fetch_addr | output | 21 | Current fetch address |

## Verification
The in-line assertions check on every cycle that the address stays even, that it steps by exactly 2 on a lone advance, that it holds when idle, that a direct load takes the load value, and that a low-byte write assembles its upper bits from the latches as they stood beforehand. They also check that latch captures and latch writes take the values presented in the previous cycle. The bench scenarios show what only a sequence can reveal: a latch write is invisible in the fetch address until a later low-byte write commits it, and a low-byte read makes the latches readable. The scenarios also cover wrap-around at the top of the address space, the two priority collisions, masking of the upper latch, and the unmapped select.

// File: rtl/pcl_pkg.sv
// Package: shared register-select encoding for the program counter block.
// Assumes a 2-bit select bus from the core's register-file decoder.
package pcl_pkg;
    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_MID  = 2'd1,
        SEL_UP   = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pc_regif.sv
// Module: pc_regif
// Decodes register accesses into per-target strobes and forms read data.
// Assumes: a write takes precedence over a read in the same cycle, so a
// low-byte capture is only raised for a read without a write.
module pc_regif
    import pcl_pkg::*;
#(
    parameter int PC_W = 21,
    localparam int UP_W = PC_W - 16
) (
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [1:0]      reg_sel,
    input  logic [7:0]      pc_lo,
    input  logic [7:0]      lat_mid,
    input  logic [UP_W-1:0] lat_up,
    output logic            lo_wr,
    output logic            mid_wr,
    output logic            up_wr,
    output logic            lo_cap,
    output logic [7:0]      rdata
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_sel);

    // Strobe decode: one target per access.
    always_comb begin
        lo_wr  = reg_wr && (sel == SEL_LO);
        mid_wr = reg_wr && (sel == SEL_MID);
        up_wr  = reg_wr && (sel == SEL_UP);
        lo_cap = reg_rd && !reg_wr && (sel == SEL_LO);
    end

    // Read mux: the unmapped select and unused upper bits read as zero.
    always_comb begin
        case (sel)
            SEL_LO:  rdata = pc_lo;
            SEL_MID: rdata = lat_mid;
            SEL_UP:  rdata = {{(8 - UP_W){1'b0}}, lat_up};
            default: rdata = 8'h00;
        endcase
    end

    // R9: the unmapped select never raises a strobe.
    always_comb begin
        if (sel == SEL_NONE) begin
            a_none_quiet_r9: assert (!(lo_wr || mid_wr || up_wr || lo_cap))
                else $error("strobe raised for unmapped select");
        end
    end
endmodule

// File: rtl/pc_shadow.sv
// Module: pc_shadow
// Staging latches for the middle and upper address fields.
// Assumes: capture and write strobes are mutually exclusive (the decoder
// guarantees this); PC_W is between 17 and 24.
module pc_shadow #(
    parameter int PC_W = 21,
    localparam int UP_W = PC_W - 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mid_wr,
    input  logic            up_wr,
    input  logic [7:0]      wdata,
    input  logic            cap,
    input  logic [7:0]      pc_mid,
    input  logic [UP_W-1:0] pc_up,
    output logic [7:0]      lat_mid,
    output logic [UP_W-1:0] lat_up
);
    // Middle latch: written by software or captured from the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      lat_mid <= '0;
        else if (cap)    lat_mid <= pc_mid;
        else if (mid_wr) lat_mid <= wdata;
    end

    // Upper latch: keeps only the low UP_W bits of a write.
    always_ff @(posedge clk) begin
        if (!rst_n)     lat_up <= '0;
        else if (cap)   lat_up <= pc_up;
        else if (up_wr) lat_up <= wdata[UP_W-1:0];
    end

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (lat_mid == $past(pc_mid)) && (lat_up == $past(pc_up)));

    p_up_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_wr && !cap) |=> lat_up == $past(wdata[UP_W-1:0]));

    p_quiet_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap || mid_wr || up_wr) |=> $stable(lat_mid) && $stable(lat_up));
endmodule

// File: rtl/pc_core.sv
// Module: pc_core
// The counter register itself, with prioritised next-address selection:
// direct load, then low-byte commit, then advance by one instruction.
// Assumes: hi_src carries {upper latch, middle latch}.
module pc_core #(
    parameter int PC_W = 21,
    localparam int HI_W = PC_W - 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            ld_vld,
    input  logic [PC_W-1:0] ld_addr,
    input  logic            lo_wr,
    input  logic [7:0]      lo_data,
    input  logic [HI_W-1:0] hi_src,
    output logic [PC_W-1:0] pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(2);

    // Counter update in priority order; bit 0 is never loaded as 1.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc <= '0;
        else if (ld_vld) pc <= {ld_addr[PC_W-1:1], 1'b0};
        else if (lo_wr)  pc <= {hi_src, lo_data[7:1], 1'b0};
        else if (adv)    pc <= pc + STEP;
    end

    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_vld |=> pc[PC_W-1:1] == $past(ld_addr[PC_W-1:1]));

    p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && !ld_vld) |=> (pc[PC_W-1:8] == $past(hi_src))
                               && (pc[7:1] == $past(lo_data[7:1])));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld_vld && !lo_wr) |=> pc == $past(pc) + STEP);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv || ld_vld || lo_wr) |=> $stable(pc));
endmodule

// File: rtl/pc_latch_unit.sv
// Module: pc_latch_unit (top)
// Program counter with software-visible low byte and staged upper fields.
// Assumes: PC_W between 17 and 24; register accesses are single-cycle.
module pc_latch_unit #(
    parameter int PC_W = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            ld_vld,
    input  logic [PC_W-1:0] ld_addr,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [1:0]      reg_sel,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    output logic [PC_W-1:0] fetch_addr
);
    localparam int UP_W = PC_W - 16;

    logic            lo_wr, mid_wr, up_wr, lo_cap;
    logic [7:0]      lat_mid;
    logic [UP_W-1:0] lat_up;
    logic [PC_W-1:0] pc;

    pc_regif #(.PC_W(PC_W)) u_regif (
        .reg_wr (reg_wr),
        .reg_rd (reg_rd),
        .reg_sel(reg_sel),
        .pc_lo  (pc[7:0]),
        .lat_mid(lat_mid),
        .lat_up (lat_up),
        .lo_wr  (lo_wr),
        .mid_wr (mid_wr),
        .up_wr  (up_wr),
        .lo_cap (lo_cap),
        .rdata  (reg_rdata)
    );

    pc_shadow #(.PC_W(PC_W)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .mid_wr (mid_wr),
        .up_wr  (up_wr),
        .wdata  (reg_wdata),
        .cap    (lo_cap),
        .pc_mid (pc[15:8]),
        .pc_up  (pc[PC_W-1:16]),
        .lat_mid(lat_mid),
        .lat_up (lat_up)
    );

    pc_core #(.PC_W(PC_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .ld_vld (ld_vld),
        .ld_addr(ld_addr),
        .lo_wr  (lo_wr),
        .lo_data(reg_wdata),
        .hi_src ({lat_up, lat_mid}),
        .pc     (pc)
    );

    assign fetch_addr = pc;

    p_even_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_addr[0] == 1'b0);

    p_latch_write_no_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel != 2'd0 && !ld_vld && !adv) |=> $stable(fetch_addr));

    p_lo_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0 && adv && !ld_vld)
            |=> fetch_addr[7:1] == $past(reg_wdata[7:1]));
endmodule

// File: tb/sim_pc_latch_unit.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results
// against a model kept from the requirements.
module sim_pc_latch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv = 1'b0, ld_vld = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [20:0] ld_addr = '0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [20:0] fetch_addr;

    int n_chk = 0;
    int n_fail = 0;
    logic [20:0] exp_pc;

    always #10 clk = ~clk;

    pc_latch_unit u0 (
        .clk(clk), .rst_n(rst_n), .adv(adv), .ld_vld(ld_vld), .ld_addr(ld_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_addr(fetch_addr)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic idle_inputs();
        adv = 0; ld_vld = 0; reg_wr = 0; reg_rd = 0; reg_sel = 2'd0;
        reg_wdata = 8'h00; ld_addr = '0;
    endtask

    // One clock: inputs already set at a negedge; return at the next negedge.
    task automatic tick();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
        reg_wr = 1; reg_sel = s; reg_wdata = d; tick();
    endtask

    function automatic logic [7:0] peek(input logic [1:0] s);
        return 8'h00;
    endfunction

    task automatic rd_reg(input logic [1:0] s, output logic [7:0] d);
        reg_sel = s; #1; d = reg_rdata; reg_sel = 2'd0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 fetch after reset", fetch_addr, 0);
        rd_reg(2'd1, v); chk("R1 middle latch after reset", v, 0);
        rd_reg(2'd2, v); chk("R1 upper latch after reset", v, 0);
        exp_pc = 0;
    endtask

    task automatic t_advance();
        for (int i = 0; i < 3; i++) begin adv = 1; tick(); end
        exp_pc = 21'd6;
        chk("R2 three advances", fetch_addr, exp_pc);
        tick();
        chk("R10 idle cycle holds", fetch_addr, exp_pc);
    endtask

    task automatic t_latch_write();
        logic [7:0] v;
        wr_reg(2'd1, 8'h34);
        wr_reg(2'd2, 8'hFF);
        rd_reg(2'd1, v); chk("R8 middle latch write", v, 8'h34);
        rd_reg(2'd2, v); chk("R8 upper latch masks bits 7:5", v, 8'h1F);
        chk("R9 latch writes leave address", fetch_addr, exp_pc);
    endtask

    task automatic t_low_write();
        wr_reg(2'd0, 8'h57);
        exp_pc = 21'h1F3456;
        chk("R4 low write commits latches", fetch_addr, exp_pc);
        chk("R3 odd write value gives even address", fetch_addr[0], 0);
    endtask

    task automatic t_low_read();
        logic [7:0] v;
        adv = 1; tick(); exp_pc = 21'h1F3458;
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd2, 8'h00);
        reg_rd = 1; reg_sel = 2'd0; #1;
        chk("R5 low byte read data", reg_rdata, 8'h58);
        tick();
        rd_reg(2'd1, v); chk("R5 capture middle", v, 8'h34);
        rd_reg(2'd2, v); chk("R5 capture upper", v, 8'h1F);
        chk("R10 read leaves address", fetch_addr, exp_pc);
    endtask

    task automatic t_jump();
        logic [7:0] v;
        wr_reg(2'd1, 8'h11);
        wr_reg(2'd2, 8'h02);
        ld_vld = 1; ld_addr = 21'h0ABCD1; tick();
        exp_pc = 21'h0ABCD0;
        chk("R6 direct load ignores latches", fetch_addr, exp_pc);
        rd_reg(2'd1, v); chk("R6 middle latch unchanged", v, 8'h11);
        rd_reg(2'd2, v); chk("R6 upper latch unchanged", v, 8'h02);
    endtask

    task automatic t_priority();
        ld_vld = 1; ld_addr = 21'h012340; reg_wr = 1; reg_sel = 2'd0; reg_wdata = 8'hAA;
        tick();
        exp_pc = 21'h012340;
        chk("R7 load beats low write", fetch_addr, exp_pc);
        adv = 1; reg_wr = 1; reg_sel = 2'd0; reg_wdata = 8'h80;
        tick();
        exp_pc = 21'h021180;
        chk("R7 low write beats advance", fetch_addr, exp_pc);
    endtask

    task automatic t_wrap();
        ld_vld = 1; ld_addr = 21'h1FFFFE; tick();
        adv = 1; tick();
        exp_pc = 0;
        chk("R2 wrap at top", fetch_addr, exp_pc);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr_reg(2'd3, 8'hFF);
        chk("R9 unmapped write leaves address", fetch_addr, exp_pc);
        rd_reg(2'd3, v); chk("R9 unmapped reads zero", v, 0);
        rd_reg(2'd1, v); chk("R9 unmapped write leaves middle latch", v, 8'h11);
        rd_reg(2'd2, v); chk("R9 unmapped write leaves upper latch", v, 8'h02);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_advance();
        t_latch_write();
        t_low_write();
        t_low_read();
        t_jump();
        t_priority();
        t_wrap();
        t_unmapped();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule